// File: doc/BRIEF.md
# Swap-Configurable Pixel Input Unpacker

This block sits at the front of one read window of an image engine. It takes a stream of 32-bit memory words and turns it into a stream of pixels. Each pixel carries four 8-bit channels: alpha, red or luma, green or blue-difference chroma, and blue or red-difference chroma. A 4-bit picture-format code selects how the bytes of a word are grouped into pixels. Two independent swap controls then vary that grouping. One swap exchanges the red and blue channels, or the two chroma channels. The other swap moves luma ahead of chroma in interleaved 4:2:2 data.

The configuration is captured on a frame-start strobe and stays fixed for the rest of the frame. Bytes are read in little-endian memory order: byte 0 is bits 7:0 of a word and comes first in memory. A byte realignment buffer lets a 3-byte pixel straddle word boundaries. Both streams use valid/ready handshakes.

Top module: `pix_unpack`

## Requirements
- R1: `fmtCode`, `rbSwap` and `ycSwap` are sampled only in a cycle where `frameStart` is high. Changes to these inputs at any other time have no effect on the pixels produced.
- R2: Code 4 (16-bit packed): each word yields two pixels, the lower halfword first. In a halfword, bits 15:11 feed red and bits 4:0 feed blue, each widened to 8 bits as {v, v[4:2]}. Bits 10:5 feed green, widened as {v, v[5:4]}.
- R3: Code 5 (3-byte): pixel bytes in memory order are blue, green, red. Pixels straddle word boundaries, so three words yield four pixels.
- R4: Code 6 (4-byte): bytes in memory order are blue, green, red, alpha.
- R5: Code 7 (4-byte, read only): bytes in memory order are alpha, blue, green, red.
- R6: With `rbSwap` set, the red and blue outputs of codes 4, 5, 6 and 7 are exchanged.
- R7: Code 1 (interleaved 4:2:2) byte orders in memory are as follows. With no swap: U Y0 V Y1. With `ycSwap` only: Y0 U Y1 V. With `rbSwap` only: V Y0 U Y1. With both swaps: Y0 V Y1 U.
- R8: Each 4:2:2 word yields two pixels, Y0 first and then Y1. Both pixels carry the same U and V values.
- R9: Codes 1, 4 and 5 output an alpha of 0xFF.
- R10: Any other code (0, 2, 3, 8 to 15) accepts and discards input words and never asserts `pixValid`.
- R11: While `pixValid` is high and `pixReady` is low, the pixel stays valid and all four channels are held, unless a frame start intervenes.
- R12: After reset, `pixValid` is low and `inReady` is high.
- R13: In the `frameStart` cycle, `inReady` is low. All buffered bytes are dropped, so `pixValid` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| frameStart | input | 1 | Frame-start strobe; captures the configuration and flushes the buffer |
| fmtCode | input | 4 | Picture-format code |
| rbSwap | input | 1 | Exchanges the red/blue or U/V channels |
| ycSwap | input | 1 | Selects luma-first order for 4:2:2 |
| inWord | input | 32 | Input memory word |
| inValid | input | 1 | Input word valid |
| inReady | output | 1 | Input word accepted when high together with `inValid` |
| pixReady | input | 1 | Downstream ready for a pixel |
| pixValid | output | 1 | Output pixel valid |
| pixAlpha | output | 8 | Alpha channel |
| pixCh1 | output | 8 | Red or Y |
| pixCh2 | output | 8 | Green or U |
| pixCh3 | output | 8 | Blue or V |

## Verification
Each format is driven with words made of distinct bytes, so that every channel's source byte position can be told apart. Each format is run both with and without the red/blue swap, which separates the swap from the base layout. The 16-bit case also uses a halfword of 0x8410, which exposes the bit replication used to widen the fields. The 3-byte case uses a counting byte sequence across three words, which shows whether the realignment crosses word boundaries correctly. All four 4:2:2 swap combinations are run on one word. Directed cases cover a configuration change in mid-frame, a held pixel under backpressure, a flush by frame start with buffered bytes, and unsupported codes.

// File: rtl/pix_unpack_pkg.sv
package pix_unpack_pkg;
  localparam int WORD_BYTES = 4;
  localparam int WORD_W     = 8 * WORD_BYTES;
  localparam int BUF_BYTES  = 2 * WORD_BYTES;
  localparam int CNT_W      = $clog2(BUF_BYTES + 1);
  localparam logic [CNT_W-1:0] WORD_CNT = CNT_W'(WORD_BYTES);

  localparam logic [3:0] FMT_YUV422 = 4'd1;
  localparam logic [3:0] FMT_PK565  = 4'd4;
  localparam logic [3:0] FMT_PK888  = 4'd5;
  localparam logic [3:0] FMT_RGBA   = 4'd6;
  localparam logic [3:0] FMT_ARGB   = 4'd7;

  // strobes from control to datapath
  typedef struct packed {
    logic             clear;
    logic             load;
    logic [CNT_W-1:0] shift;
    logic [CNT_W-1:0] loadPos;
  } dpCtrl_t;
endpackage

// File: rtl/pix_unpack_ctrl.sv
module pix_unpack_ctrl
  import pix_unpack_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameStart,
  input  logic [3:0] fmtCode,
  input  logic       rbSwapIn,
  input  logic       ycSwapIn,
  input  logic       inValid,
  output logic       inReady,
  input  logic       pixReady,
  output logic       pixValid,
  output dpCtrl_t    ctrl,
  output logic [3:0] fmtQ,
  output logic       rbQ,
  output logic       ycQ,
  output logic       halfQ
);
  logic [CNT_W-1:0] fill;
  logic [CNT_W-1:0] bpp;
  logic supported, pairMode, fire, consume, accept;

  always_comb begin
    supported = 1'b1;
    pairMode  = 1'b0;
    bpp       = WORD_CNT;
    case (fmtQ)
      FMT_PK565:  bpp = CNT_W'(2);
      FMT_PK888:  bpp = CNT_W'(3);
      FMT_RGBA, FMT_ARGB: bpp = WORD_CNT;
      FMT_YUV422: pairMode = 1'b1;
      default:    supported = 1'b0;
    endcase
  end

  assign pixValid = supported && !frameStart && (fill >= bpp);
  assign fire     = pixValid && pixReady;
  assign consume  = fire && (!pairMode || halfQ);
  assign inReady  = !frameStart && (!supported || fill <= WORD_CNT);
  assign accept   = inValid && inReady && supported;

  always_comb begin
    ctrl.clear   = frameStart;
    ctrl.load    = accept;
    ctrl.shift   = consume ? bpp : '0;
    ctrl.loadPos = fill - ctrl.shift;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fmtQ  <= 4'd0;
      rbQ   <= 1'b0;
      ycQ   <= 1'b0;
      fill  <= '0;
      halfQ <= 1'b0;
    end else if (frameStart) begin
      fmtQ  <= fmtCode;
      rbQ   <= rbSwapIn;
      ycQ   <= ycSwapIn;
      fill  <= '0;
      halfQ <= 1'b0;
    end else begin
      fill <= fill - ctrl.shift + (accept ? WORD_CNT : '0);
      if (fire && pairMode) halfQ <= ~halfQ;
    end
  end
endmodule

// File: rtl/pix_unpack_dp.sv
module pix_unpack_dp
  import pix_unpack_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic [WORD_W-1:0] inWord,
  input  logic [3:0]        fmtQ,
  input  logic              rbQ,
  input  logic              ycQ,
  input  logic              halfQ,
  output logic [7:0]        alphaOut,
  output logic [7:0]        ch1Out,
  output logic [7:0]        ch2Out,
  output logic [7:0]        ch3Out
);
  logic [BUF_BYTES-1:0][7:0] byteQ, byteNext;

  // realignment: drop consumed bytes, append the new word behind the rest
  always_comb begin
    for (int i = 0; i < BUF_BYTES; i++) begin
      if (i + int'(ctrl.shift) < BUF_BYTES) byteNext[i] = byteQ[i + int'(ctrl.shift)];
      else byteNext[i] = 8'h00;
    end
    if (ctrl.load) begin
      for (int k = 0; k < WORD_BYTES; k++) begin
        if (int'(ctrl.loadPos) + k < BUF_BYTES)
          byteNext[int'(ctrl.loadPos) + k] = inWord[8*k +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) byteQ <= '0;
    else if (ctrl.clear) byteQ <= '0;
    else byteQ <= byteNext;
  end

  logic [7:0]  b0, b1, b2, b3, hiX, loX, midX, yA, yB, cA, cB;
  logic [15:0] half16;

  always_comb begin
    b0 = byteQ[0];
    b1 = byteQ[1];
    b2 = byteQ[2];
    b3 = byteQ[3];
    half16 = {b1, b0};
    hiX  = {half16[15:11], half16[15:13]};
    loX  = {half16[4:0], half16[4:2]};
    midX = {half16[10:5], half16[10:9]};
    yA = ycQ ? b0 : b1;
    yB = ycQ ? b2 : b3;
    cA = ycQ ? b1 : b0;
    cB = ycQ ? b3 : b2;
    alphaOut = 8'hFF;
    ch1Out = 8'h00;
    ch2Out = 8'h00;
    ch3Out = 8'h00;
    case (fmtQ)
      FMT_PK565: begin
        ch1Out = rbQ ? loX : hiX;
        ch2Out = midX;
        ch3Out = rbQ ? hiX : loX;
      end
      FMT_PK888, FMT_RGBA: begin
        if (fmtQ == FMT_RGBA) alphaOut = b3;
        ch1Out = rbQ ? b0 : b2;
        ch2Out = b1;
        ch3Out = rbQ ? b2 : b0;
      end
      FMT_ARGB: begin
        alphaOut = b0;
        ch1Out = rbQ ? b1 : b3;
        ch2Out = b2;
        ch3Out = rbQ ? b3 : b1;
      end
      FMT_YUV422: begin
        ch1Out = halfQ ? yB : yA;
        ch2Out = rbQ ? cB : cA;
        ch3Out = rbQ ? cA : cB;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pix_unpack.sv
module pix_unpack
  import pix_unpack_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameStart,
  input  logic [3:0]  fmtCode,
  input  logic        rbSwap,
  input  logic        ycSwap,
  input  logic [31:0] inWord,
  input  logic        inValid,
  output logic        inReady,
  input  logic        pixReady,
  output logic        pixValid,
  output logic [7:0]  pixAlpha,
  output logic [7:0]  pixCh1,
  output logic [7:0]  pixCh2,
  output logic [7:0]  pixCh3
);
  dpCtrl_t    ctrl;
  logic [3:0] fmtQ;
  logic       rbQ, ycQ, halfQ;

  pix_unpack_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .fmtCode(fmtCode),
    .rbSwapIn(rbSwap), .ycSwapIn(ycSwap), .inValid(inValid), .inReady(inReady),
    .pixReady(pixReady), .pixValid(pixValid), .ctrl(ctrl), .fmtQ(fmtQ),
    .rbQ(rbQ), .ycQ(ycQ), .halfQ(halfQ)
  );

  pix_unpack_dp u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .inWord(inWord), .fmtQ(fmtQ),
    .rbQ(rbQ), .ycQ(ycQ), .halfQ(halfQ), .alphaOut(pixAlpha),
    .ch1Out(pixCh1), .ch2Out(pixCh2), .ch3Out(pixCh3)
  );
endmodule

// File: rtl/pix_unpack_chk.sv
module pix_unpack_chk (
  input logic       clk,
  input logic       rstN,
  input logic       frameStart,
  input logic       inReady,
  input logic       pixReady,
  input logic       pixValid,
  input logic [7:0] pixAlpha,
  input logic [7:0] pixCh1,
  input logic [7:0] pixCh2,
  input logic [7:0] pixCh3,
  input logic [3:0] fmtQ,
  input logic       halfQ
);
  // R13
  frame_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> !inReady);
  // R13
  frame_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> !pixValid);
  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && !pixReady && !frameStart) |=>
      (frameStart || (pixValid && $stable({pixAlpha, pixCh1, pixCh2, pixCh3}))));
  // R9
  opaque_alpha_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && (fmtQ == 4'd1 || fmtQ == 4'd4 || fmtQ == 4'd5)) |-> pixAlpha == 8'hFF);
  // R10
  unsupported_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |-> (fmtQ == 4'd1 || fmtQ == 4'd4 || fmtQ == 4'd5 || fmtQ == 4'd6 || fmtQ == 4'd7));
  // R8
  pair_chroma_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && pixReady && !frameStart && fmtQ == 4'd1 && !halfQ) |=>
      (frameStart || (pixValid && $stable({pixCh2, pixCh3}))));
endmodule

bind pix_unpack pix_unpack_chk u_chk (
  .clk(clk), .rstN(rstN), .frameStart(frameStart), .inReady(inReady),
  .pixReady(pixReady), .pixValid(pixValid), .pixAlpha(pixAlpha),
  .pixCh1(pixCh1), .pixCh2(pixCh2), .pixCh3(pixCh3), .fmtQ(fmtQ), .halfQ(halfQ)
);

// File: tb/pix_unpack_tb.sv
module pix_unpack_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 15;

  typedef struct packed {
    logic [3:0]       fmt;
    logic             rb;
    logic             yc;
    logic [1:0]       nW;
    logic [2:0][31:0] w;
    logic [2:0]       nP;
    logic [3:0][31:0] p;
  } vec_t;

  // pixels packed as {alpha, ch1, ch2, ch3}
  localparam vec_t VECS [NVEC] = '{
    '{4'd4, 1'b0, 1'b0, 2'd1, {32'h0, 32'h0, 32'h07E0F800}, 3'd2, {32'h0, 32'h0, 32'hFF00FF00, 32'hFFFF0000}},
    '{4'd4, 1'b1, 1'b0, 2'd1, {32'h0, 32'h0, 32'h07E0F800}, 3'd2, {32'h0, 32'h0, 32'hFF00FF00, 32'hFF0000FF}},
    '{4'd4, 1'b0, 1'b0, 2'd1, {32'h0, 32'h0, 32'h001F8410}, 3'd2, {32'h0, 32'h0, 32'hFF0000FF, 32'hFF848284}},
    '{4'd5, 1'b0, 1'b0, 2'd3, {32'h0C0B0A09, 32'h08070605, 32'h04030201}, 3'd4,
      {32'hFF0C0B0A, 32'hFF090807, 32'hFF060504, 32'hFF030201}},
    '{4'd5, 1'b1, 1'b0, 2'd3, {32'h0C0B0A09, 32'h08070605, 32'h04030201}, 3'd4,
      {32'hFF0A0B0C, 32'hFF070809, 32'hFF040506, 32'hFF010203}},
    '{4'd6, 1'b0, 1'b0, 2'd2, {32'h0, 32'h88776655, 32'h44332211}, 3'd2, {32'h0, 32'h0, 32'h88776655, 32'h44332211}},
    '{4'd6, 1'b1, 1'b0, 2'd1, {32'h0, 32'h0, 32'h44332211}, 3'd1, {32'h0, 32'h0, 32'h0, 32'h44112233}},
    '{4'd7, 1'b0, 1'b0, 2'd1, {32'h0, 32'h0, 32'h44332211}, 3'd1, {32'h0, 32'h0, 32'h0, 32'h11443322}},
    '{4'd7, 1'b1, 1'b0, 2'd1, {32'h0, 32'h0, 32'h44332211}, 3'd1, {32'h0, 32'h0, 32'h0, 32'h11223344}},
    '{4'd1, 1'b0, 1'b0, 2'd1, {32'h0, 32'h0, 32'h44332211}, 3'd2, {32'h0, 32'h0, 32'hFF441133, 32'hFF221133}},
    '{4'd1, 1'b0, 1'b1, 2'd1, {32'h0, 32'h0, 32'h44332211}, 3'd2, {32'h0, 32'h0, 32'hFF332244, 32'hFF112244}},
    '{4'd1, 1'b1, 1'b0, 2'd1, {32'h0, 32'h0, 32'h44332211}, 3'd2, {32'h0, 32'h0, 32'hFF443311, 32'hFF223311}},
    '{4'd1, 1'b1, 1'b1, 2'd1, {32'h0, 32'h0, 32'h44332211}, 3'd2, {32'h0, 32'h0, 32'hFF334422, 32'hFF114422}},
    '{4'd0, 1'b0, 1'b0, 2'd1, {32'h0, 32'h0, 32'h12345678}, 3'd0, {32'h0, 32'h0, 32'h0, 32'h0}},
    '{4'd9, 1'b1, 1'b1, 2'd2, {32'h0, 32'h9ABCDEF0, 32'h12345678}, 3'd0, {32'h0, 32'h0, 32'h0, 32'h0}}
  };

  function automatic string tagOf(int i);
    case (i)
      0, 2:         return "R2 R9";
      1, 4, 6:      return "R6";
      3:            return "R3 R9";
      5:            return "R4";
      7:            return "R5";
      8:            return "R5 R6";
      9:            return "R7 R8";
      10, 11, 12:   return "R7";
      default:      return "R10";
    endcase
  endfunction

  logic clk = 1'b0, rstN = 1'b0, frameStart = 1'b0;
  logic [3:0] fmtCode = 4'd0;
  logic rbSwap = 1'b0, ycSwap = 1'b0, inValid = 1'b0, pixReady = 1'b0;
  logic [31:0] inWord = 32'h0;
  logic inReady, pixValid;
  logic [7:0] pixAlpha, pixCh1, pixCh2, pixCh3;

  int total = 0, bad = 0, cyc = 0, gotN = 0;
  bit collecting = 1'b0, finished = 1'b0;
  logic [31:0] got [8];

  pix_unpack u_dut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .fmtCode(fmtCode),
    .rbSwap(rbSwap), .ycSwap(ycSwap), .inWord(inWord), .inValid(inValid),
    .inReady(inReady), .pixReady(pixReady), .pixValid(pixValid),
    .pixAlpha(pixAlpha), .pixCh1(pixCh1), .pixCh2(pixCh2), .pixCh3(pixCh3)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    if (collecting && pixValid && pixReady) begin
      if (gotN < 8) got[gotN] = {pixAlpha, pixCh1, pixCh2, pixCh3};
      gotN++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !finished) begin
      bad++;
      total++;
      $display("FAIL watchdog (all requirements) actual=hang expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic startFrame(logic [3:0] f, logic rb, logic yc);
    @(negedge clk);
    frameStart = 1'b1;
    fmtCode = f;
    rbSwap = rb;
    ycSwap = yc;
    #1;
    chk(inReady == 1'b0, "R13 inReady during frame start", 32'(inReady), 32'd0);
    @(negedge clk);
    frameStart = 1'b0;
  endtask

  task automatic sendWord(logic [31:0] w);
    @(negedge clk);
    inValid = 1'b1;
    inWord = w;
    #1;
    while (!inReady) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic drain();
    repeat (8) @(negedge clk);
    collecting = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(pixValid == 1'b0, "R12 pixValid in reset", 32'(pixValid), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(pixValid == 1'b0, "R12 pixValid after reset", 32'(pixValid), 32'd0);
    chk(inReady == 1'b1, "R12 inReady after reset", 32'(inReady), 32'd1);

    // table of formats and swaps
    for (int i = 0; i < NVEC; i++) begin
      startFrame(VECS[i].fmt, VECS[i].rb, VECS[i].yc);
      pixReady = 1'b1;
      gotN = 0;
      collecting = 1'b1;
      for (int k = 0; k < int'(VECS[i].nW); k++) sendWord(VECS[i].w[k]);
      drain();
      chk(gotN == int'(VECS[i].nP), {tagOf(i), " pixel count"}, 32'(gotN), 32'(VECS[i].nP));
      for (int k = 0; k < int'(VECS[i].nP); k++)
        chk(got[k] === VECS[i].p[k], {tagOf(i), " pixel value"}, got[k], VECS[i].p[k]);
    end

    // R1: configuration change in mid-frame is ignored
    startFrame(4'd6, 1'b0, 1'b0);
    @(negedge clk);
    fmtCode = 4'd4;
    rbSwap = 1'b1;
    ycSwap = 1'b1;
    gotN = 0;
    collecting = 1'b1;
    sendWord(32'h44332211);
    drain();
    chk(gotN == 1, "R1 pixel count", 32'(gotN), 32'd1);
    chk(got[0] === 32'h44332211, "R1 pixel value", got[0], 32'h44332211);

    // R11: held pixel under backpressure
    startFrame(4'd6, 1'b0, 1'b0);
    pixReady = 1'b0;
    sendWord(32'hA1B2C3D4);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(pixValid == 1'b1, "R11 valid while stalled", 32'(pixValid), 32'd1);
      chk({pixAlpha, pixCh1, pixCh2, pixCh3} === 32'hA1B2C3D4, "R11 data while stalled",
          {pixAlpha, pixCh1, pixCh2, pixCh3}, 32'hA1B2C3D4);
    end
    pixReady = 1'b1;
    @(negedge clk);
    chk(pixValid == 1'b0, "R11 valid after release", 32'(pixValid), 32'd0);

    // R13: frame start flushes buffered bytes
    startFrame(4'd6, 1'b0, 1'b0);
    pixReady = 1'b0;
    sendWord(32'h11111111);
    sendWord(32'h22222222);
    startFrame(4'd6, 1'b0, 1'b0);
    chk(pixValid == 1'b0, "R13 valid after flush", 32'(pixValid), 32'd0);
    pixReady = 1'b1;
    gotN = 0;
    collecting = 1'b1;
    sendWord(32'h33333333);
    drain();
    chk(gotN == 1, "R13 pixel count after flush", 32'(gotN), 32'd1);
    chk(got[0] === 32'h33333333, "R13 pixel after flush", got[0], 32'h33333333);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule